// File: doc/BRIEF.md
# Speculative Separable Switch Allocator

This block decides, each cycle, which input virtual channels of a virtual-channel router may cross the crossbar. The router has P input ports, P output ports and V virtual channels on each input. Every input VC that holds a flit presents a request, the output port it wants, and a flag. The flag says whether the request is speculative (a head flit whose VC allocation is being resolved in this same cycle) or non-speculative (body and tail flits, or a head flit that already holds an output VC).

Two separable allocators run side by side, one for each request class. In each one, a V:1 round-robin arbiter at every input picks one VC. A P:1 round-robin arbiter at every output then picks one of the inputs whose chosen VC targets that output. A merge stage gives each output to the non-speculative winner if there is one. Otherwise the output goes to the speculative winner, but only if that flit's VC allocation succeeded in the same cycle and its input port received no non-speculative grant. Grants are combinational in the cycle of the request. Arbiter priority registers move only when a grant survives the merge.

Top module: `spec_sw_alloc`

## Requirements
- R1: A lone non-speculative request from input i, VC v to output o sets grant bit i*V+v in the same cycle, sets the output's valid bit `xb_vld[o]`, and drives `xb_sel[o]` to i.
- R2: At most one VC of any input port is granted per cycle. The VCs of one input that compete for the switch take turns in round-robin order.
- R3: Each output grants at most one input per cycle. Inputs competing for one output take turns in round-robin order.
- R4: When a non-speculative and a speculative request win the same output, the non-speculative one is granted.
- R5: A speculative request is granted only when its VC-allocation success bit is high in the same cycle. Otherwise no grant is issued and the output's valid bit stays low.
- R6: An arbiter's priority moves past a winner only when that winner's grant is issued after the merge. A winner that is overridden or suppressed keeps top priority for the next cycle.
- R7: An input port that holds a non-speculative grant receives no speculative grant in the same cycle.
- R8: After reset, every arbiter favours index 0. With no requests, no grant bit and no output valid bit is set.
- R9: Every grant goes to a VC with a valid request, and that VC's target output shows valid with its input as the select.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_vld | input | P*V | Request present, bit i*V+v for input i, VC v |
| req_port | input | P*V*PW | Target output index per input VC, PW bits each |
| req_spec | input | P*V | 1 = speculative request, 0 = non-speculative |
| va_ok | input | P*V | VC allocation succeeded this cycle (used for speculative requests) |
| vc_gnt | output | P*V | Switch grant per input VC |
| xb_vld | output | P | Output port has a granted input this cycle |
| xb_sel | output | P*PW | Crossbar select per output: index of the granted input |

## Verification
The assertions assume that `req_port` holds an index below P for every VC whose request bit is set. They also assume that requests are held stable between clock edges, because the grants are combinational and the priority registers sample them at the edge. The stimulus drives only legal port indices, changes inputs away from the rising edge, and clears every request bit it does not use. Reset is applied before each scenario, so every arbiter's priority is known when the scenario's first cycle is checked.

// File: rtl/swa_pkg.sv
`timescale 1ns/1ps
package swa_pkg;

    // Which allocator supplied the winner of an output after the merge.
    typedef enum logic [1:0] {
        SRC_NONE = 2'd0,
        SRC_NS   = 2'd1,
        SRC_SPEC = 2'd2
    } grant_src_e;

    // Per-output merge result.
    typedef struct packed {
        grant_src_e src;
        logic [7:0] who;
    } merge_t;

    // Index following idx in a ring of n entries.
    function automatic int ring_next(input int idx, input int n);
        return (idx >= n - 1) ? 0 : idx + 1;
    endfunction

endpackage

// File: rtl/swa_rr_arb.sv
`timescale 1ns/1ps
module swa_rr_arb #(
    parameter int N = 4,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] req,
    input  logic         upd,
    output logic [N-1:0] gnt
);
    import swa_pkg::*;

    logic [IW-1:0] ptr;
    logic [IW-1:0] ptr_nxt;

    // Search from the pointer, wrapping once around the ring.
    always_comb begin
        int idx;
        logic found;
        gnt   = '0;
        found = 1'b0;
        for (int k = 0; k < N; k++) begin
            idx = int'(ptr) + k;
            if (idx >= N) idx = idx - N;
            if (!found && req[idx]) begin
                gnt[idx] = 1'b1;
                found    = 1'b1;
            end
        end
    end

    // The entry after the winner becomes the highest priority.
    always_comb begin
        ptr_nxt = ptr;
        for (int k = 0; k < N; k++) begin
            if (gnt[k]) ptr_nxt = IW'(ring_next(k, N));
        end
    end

    always_ff @(posedge clk) begin
        if (rst)                ptr <= '0;
        else if (upd && |gnt)   ptr <= ptr_nxt;
    end

    AST_ARB_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $onehot0(gnt)); // R3
    AST_ARB_HAS_REQ: assert property (@(posedge clk) disable iff (rst)
        (gnt & ~req) == '0); // R9
    AST_PTR_HOLD: assert property (@(posedge clk) disable iff (rst)
        !upd |=> $stable(ptr)); // R6

endmodule

// File: rtl/swa_sep_alloc.sv
`timescale 1ns/1ps
module swa_sep_alloc #(
    parameter int P = 5,
    parameter int V = 4,
    localparam int PW = (P > 1) ? $clog2(P) : 1,
    localparam int NI = P * V
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [NI-1:0]   rq,
    input  logic [NI*PW-1:0] rq_port,
    input  logic [P-1:0]    in_used,
    input  logic [P-1:0]    out_used,
    output logic [NI-1:0]   s1_gnt,
    output logic [P*P-1:0]  s2_gnt
);
    logic [P-1:0]  win_any;
    logic [PW-1:0] win_port [P];
    logic [P-1:0]  s2_req [P];

    // First stage: one V:1 arbiter per input port.
    for (genvar i = 0; i < P; i++) begin : g_in
        swa_rr_arb #(.N(V)) u_s1 (
            .clk (clk),
            .rst (rst),
            .req (rq[i*V +: V]),
            .upd (in_used[i]),
            .gnt (s1_gnt[i*V +: V])
        );

        always_comb begin
            win_any[i]  = |s1_gnt[i*V +: V];
            win_port[i] = '0;
            for (int v = 0; v < V; v++) begin
                if (s1_gnt[i*V + v]) win_port[i] = rq_port[(i*V + v)*PW +: PW];
            end
        end
    end

    // Second stage: one P:1 arbiter per output port.
    for (genvar o = 0; o < P; o++) begin : g_out
        always_comb begin
            for (int i = 0; i < P; i++) begin
                s2_req[o][i] = win_any[i] && (int'(win_port[i]) == o);
            end
        end

        swa_rr_arb #(.N(P)) u_s2 (
            .clk (clk),
            .rst (rst),
            .req (s2_req[o]),
            .upd (out_used[o]),
            .gnt (s2_gnt[o*P +: P])
        );
    end

    for (genvar i = 0; i < P; i++) begin : g_chk
        AST_S1_ONE_VC: assert property (@(posedge clk) disable iff (rst)
            $onehot0(s1_gnt[i*V +: V])); // R2
    end

endmodule

// File: rtl/spec_sw_alloc.sv
`timescale 1ns/1ps
module spec_sw_alloc #(
    parameter int P = 5,
    parameter int V = 4,
    localparam int PW = (P > 1) ? $clog2(P) : 1,
    localparam int NI = P * V
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NI-1:0]     req_vld,
    input  logic [NI*PW-1:0]  req_port,
    input  logic [NI-1:0]     req_spec,
    input  logic [NI-1:0]     va_ok,
    output logic [NI-1:0]     vc_gnt,
    output logic [P-1:0]      xb_vld,
    output logic [P*PW-1:0]   xb_sel
);
    import swa_pkg::*;

    logic [NI-1:0]  ns_rq, sp_rq;
    logic [NI-1:0]  ns_s1, sp_s1;
    logic [P*P-1:0] ns_s2, sp_s2;
    logic [P-1:0]   ns_in_used, ns_out_used;
    logic [P-1:0]   sp_in_used, sp_out_used;
    logic [P-1:0]   in_ns_busy, in_va_hit;
    merge_t         mrg [P];

    assign ns_rq = req_vld & ~req_spec;
    assign sp_rq = req_vld &  req_spec;

    swa_sep_alloc #(.P(P), .V(V)) u_ns (
        .clk      (clk),
        .rst      (rst),
        .rq       (ns_rq),
        .rq_port  (req_port),
        .in_used  (ns_in_used),
        .out_used (ns_out_used),
        .s1_gnt   (ns_s1),
        .s2_gnt   (ns_s2)
    );

    swa_sep_alloc #(.P(P), .V(V)) u_sp (
        .clk      (clk),
        .rst      (rst),
        .rq       (sp_rq),
        .rq_port  (req_port),
        .in_used  (sp_in_used),
        .out_used (sp_out_used),
        .s1_gnt   (sp_s1),
        .s2_gnt   (sp_s2)
    );

    // Per-input facts the merge needs.
    always_comb begin
        for (int i = 0; i < P; i++) begin
            in_ns_busy[i] = 1'b0;
            for (int o = 0; o < P; o++) begin
                if (ns_s2[o*P + i]) in_ns_busy[i] = 1'b1;
            end
            in_va_hit[i] = |(sp_s1[i*V +: V] & va_ok[i*V +: V]);
        end
    end

    // Merge: non-speculative first, then a qualified speculative winner.
    always_comb begin
        for (int o = 0; o < P; o++) begin
            mrg[o].src = SRC_NONE;
            mrg[o].who = '0;
            for (int i = 0; i < P; i++) begin
                if (ns_s2[o*P + i]) begin
                    mrg[o].src = SRC_NS;
                    mrg[o].who = 8'(i);
                end
            end
            if (mrg[o].src == SRC_NONE) begin
                for (int i = 0; i < P; i++) begin
                    if (sp_s2[o*P + i] && in_va_hit[i] && !in_ns_busy[i]) begin
                        mrg[o].src = SRC_SPEC;
                        mrg[o].who = 8'(i);
                    end
                end
            end
        end
    end

    // Which arbiters saw their grant used.
    always_comb begin
        ns_in_used  = in_ns_busy;
        sp_in_used  = '0;
        for (int o = 0; o < P; o++) begin
            ns_out_used[o] = (mrg[o].src == SRC_NS);
            sp_out_used[o] = (mrg[o].src == SRC_SPEC);
            if (mrg[o].src == SRC_SPEC) sp_in_used[int'(mrg[o].who)] = 1'b1;
        end
    end

    // Outputs.
    always_comb begin
        for (int i = 0; i < P; i++) begin
            if (in_ns_busy[i])      vc_gnt[i*V +: V] = ns_s1[i*V +: V];
            else if (sp_in_used[i]) vc_gnt[i*V +: V] = sp_s1[i*V +: V];
            else                    vc_gnt[i*V +: V] = '0;
        end
        for (int o = 0; o < P; o++) begin
            xb_vld[o]            = (mrg[o].src != SRC_NONE);
            xb_sel[o*PW +: PW]   = PW'(mrg[o].who);
        end
    end

    for (genvar i = 0; i < P; i++) begin : g_in_chk
        AST_ONE_PER_INPUT: assert property (@(posedge clk) disable iff (rst)
            $countones(vc_gnt[i*V +: V]) <= 1); // R2
        AST_NS_EXCLUDES_SPEC: assert property (@(posedge clk) disable iff (rst)
            in_ns_busy[i] |-> !sp_in_used[i]); // R7
    end

    for (genvar k = 0; k < NI; k++) begin : g_vc_chk
        AST_SPEC_NEEDS_VA: assert property (@(posedge clk) disable iff (rst)
            (vc_gnt[k] && req_spec[k]) |-> va_ok[k]); // R5
        AST_GNT_HAS_REQ: assert property (@(posedge clk) disable iff (rst)
            vc_gnt[k] |-> req_vld[k]); // R9
        AST_GNT_MATCHES_XB: assert property (@(posedge clk) disable iff (rst)
            vc_gnt[k] |-> (xb_vld[req_port[k*PW +: PW]] &&
                           int'(xb_sel[req_port[k*PW +: PW]*PW +: PW]) == k / V)); // R9
    end

    for (genvar o = 0; o < P; o++) begin : g_out_chk
        AST_NS_WINS_OUTPUT: assert property (@(posedge clk) disable iff (rst)
            (|ns_s2[o*P +: P]) |-> (xb_vld[o] && mrg[o].src == SRC_NS)); // R4
    end

endmodule

// File: tb/spec_sw_alloc_test.sv
`timescale 1ns/1ps
module spec_sw_alloc_test;
    localparam int P  = 4;
    localparam int V  = 2;
    localparam int PW = 2;
    localparam int NI = P * V;

    logic              clk = 1'b0;
    logic              rst;
    logic [NI-1:0]     req_vld;
    logic [NI*PW-1:0]  req_port;
    logic [NI-1:0]     req_spec;
    logic [NI-1:0]     va_ok;
    logic [NI-1:0]     vc_gnt;
    logic [P-1:0]      xb_vld;
    logic [P*PW-1:0]   xb_sel;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    spec_sw_alloc #(.P(P), .V(V)) uut (
        .clk      (clk),
        .rst      (rst),
        .req_vld  (req_vld),
        .req_port (req_port),
        .req_spec (req_spec),
        .va_ok    (va_ok),
        .vc_gnt   (vc_gnt),
        .xb_vld   (xb_vld),
        .xb_sel   (xb_sel)
    );

    task automatic clr();
        req_vld  = '0;
        req_port = '0;
        req_spec = '0;
        va_ok    = '0;
    endtask

    task automatic put(input int i, input int v, input int port, input bit spec, input bit ok);
        req_vld[i*V + v]             = 1'b1;
        req_port[(i*V + v)*PW +: PW] = PW'(port);
        req_spec[i*V + v]            = spec;
        va_ok[i*V + v]               = ok;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        clr();
        @(posedge clk);
        @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    // Called at a negedge after inputs are set; samples mid low phase.
    task automatic chk_gnt(input logic [NI-1:0] exp, input string tag);
        #2;
        checks++;
        if (vc_gnt !== exp) begin
            errors++;
            $display("FAIL %s vc_gnt actual %b expected %b", tag, vc_gnt, exp);
        end
    endtask

    task automatic chk_out(input int o, input bit vld, input int sel, input string tag);
        checks++;
        if (xb_vld[o] !== vld || (vld && int'(xb_sel[o*PW +: PW]) != sel)) begin
            errors++;
            $display("FAIL %s out %0d actual vld %b sel %0d expected vld %b sel %0d",
                     tag, o, xb_vld[o], xb_sel[o*PW +: PW], vld, sel);
        end
    endtask

    task automatic t_reset();
        do_reset();
        chk_gnt(8'h00, "R8 idle grants");
        checks++;
        if (xb_vld !== '0) begin
            errors++;
            $display("FAIL R8 xb_vld actual %b expected 0000", xb_vld);
        end
    endtask

    task automatic t_single();
        do_reset();
        put(2, 1, 3, 1'b0, 1'b0);
        chk_gnt(8'h20, "R1 single ns");
        chk_out(3, 1'b1, 2, "R1 single ns");
    endtask

    task automatic t_input_rr();
        do_reset();
        put(0, 0, 1, 1'b0, 1'b0);
        put(0, 1, 2, 1'b0, 1'b0);
        chk_gnt(8'h01, "R2 R8 first vc");
        chk_out(2, 1'b0, 0, "R2 other vc idle");
        @(negedge clk);
        chk_gnt(8'h02, "R2 vc rotation");
        chk_out(2, 1'b1, 0, "R2 vc rotation");
    endtask

    task automatic t_output_rr();
        do_reset();
        put(0, 0, 0, 1'b0, 1'b0);
        put(1, 0, 0, 1'b0, 1'b0);
        chk_gnt(8'h01, "R3 first input");
        chk_out(0, 1'b1, 0, "R3 first input");
        @(negedge clk);
        chk_gnt(8'h04, "R3 input rotation");
        chk_out(0, 1'b1, 1, "R3 input rotation");
    endtask

    task automatic t_priority();
        do_reset();
        put(0, 0, 2, 1'b1, 1'b1);
        put(1, 0, 2, 1'b0, 1'b0);
        chk_gnt(8'h04, "R4 ns over spec");
        chk_out(2, 1'b1, 1, "R4 ns over spec");
    endtask

    task automatic t_spec_va();
        do_reset();
        put(3, 0, 1, 1'b1, 1'b1);
        chk_gnt(8'h40, "R5 spec with va");
        chk_out(1, 1'b1, 3, "R5 spec with va");
        @(negedge clk);
        va_ok = '0;
        chk_gnt(8'h00, "R5 spec va fail");
        chk_out(1, 1'b0, 0, "R5 spec va fail");
    endtask

    task automatic t_input_excl();
        do_reset();
        put(0, 0, 1, 1'b0, 1'b0);
        put(0, 1, 2, 1'b1, 1'b1);
        chk_gnt(8'h01, "R7 input exclusive");
        chk_out(2, 1'b0, 0, "R7 input exclusive");
    endtask

    task automatic t_hold_ptr();
        do_reset();
        put(0, 0, 0, 1'b1, 1'b1);
        put(1, 0, 0, 1'b1, 1'b1);
        put(2, 1, 0, 1'b0, 1'b0);
        chk_gnt(8'h20, "R6 ns overrides");
        chk_out(0, 1'b1, 2, "R6 ns overrides");
        @(negedge clk);
        req_vld[2*V + 1] = 1'b0;
        chk_gnt(8'h01, "R6 spec priority kept");
        chk_out(0, 1'b1, 0, "R6 spec priority kept");
    endtask

    initial begin
        #(8 * 5000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        rst = 1'b1;
        clr();
        t_reset();
        t_single();
        t_input_rr();
        t_output_rr();
        t_priority();
        t_spec_va();
        t_input_excl();
        t_hold_ptr();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule